// File: doc/BRIEF.md
# Tiled Surface Address Swizzler

This block corrects bit 6 of a byte address so that tiled surfaces written through one address decoder are read back correctly through another. Each access carries a tiling kind (linear, X-tiled or Y-tiled) and an address. For tiled accesses, bit 6 is XORed with a set of higher address bits. That set is picked per tiling kind from a swizzle mode held inside the block.

The swizzle modes come from memory-configuration inputs sampled on a load strobe. Two decode styles are offered. The interleave style looks at a channel addressing field and two channel-XOR flags. The DIMM style compares the size fields of the two channels. If the configuration read failed, the block enters an unknown mode. In that mode it refuses to rewrite tiled accesses and raises an error flag instead.

Translation is a one-stage pipeline with valid/ready handshakes on both sides.

Top module: `swz_top`

Mode codes reported on `mode_x` and `mode_y`:

| Code | Mode |
|---|---|
| 0 | none |
| 1 | bit 9 |
| 2 | bits 9 and 10 |
| 3 | bits 9 and 11 |
| 4 | bits 9, 10 and 11 |
| 5 | bits 9 and 17 |
| 6 | bits 9, 10 and 17 |
| 7 | unknown |

Tile codes on `in_tile`: 0 is linear, 1 is X-tiled, 2 is Y-tiled, 3 is reserved.

## Requirements
- R1: After reset both `mode_x` and `mode_y` read 7 (unknown), `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_dimm_style`=0, `cfg_read_ok`=1 and `cfg_chan_mode` equal to 0 (single channel) or 1 (asymmetric dual channel), a load sets both modes to 0.
- R3: With `cfg_dimm_style`=0, `cfg_read_ok`=1, `cfg_chan_mode`=2 (interleaved) and `cfg_xor_off`=1, a load sets `mode_x`=2 and `mode_y`=1.
- R4: In the interleaved case of R3 but with `cfg_xor_off`=0, a load gives `mode_x`=4 and `mode_y`=3 when `cfg_xor_b17`=0. It gives `mode_x`=6 and `mode_y`=5 when `cfg_xor_b17`=1.
- R5: A load with `cfg_read_ok`=0 sets both modes to 7, whatever the other inputs are. A load with `cfg_dimm_style`=0 and `cfg_chan_mode`=3 also sets both modes to 7.
- R6: With `cfg_dimm_style`=1 and `cfg_read_ok`=1, a load gives `mode_x`=2 and `mode_y`=1 when `cfg_dimm_a` equals `cfg_dimm_b`. It gives 0 for both modes when the two fields differ.
- R7: The modes change only in the cycle after a clock edge where `cfg_load`=1. Configuration inputs that change without a load have no effect.
- R8: For an accepted access with tile 1 (X), the output bit 6 equals input bit 6 XORed with every bit listed in `mode_x`. Tile 2 (Y) uses `mode_y` in the same way. All other bits pass through unchanged.
- R9: An accepted access with tile 0 or 3 is output unchanged, with `out_err`=0.
- R10: An accepted tiled access (tile 1 or 2) whose selected mode is 7 is output unchanged, with `out_err`=1.
- R11: An access accepted on a clock edge appears on the output after exactly that edge. `in_ready` equals NOT `out_valid` OR `out_ready`. `out_valid` falls after an edge where `out_ready`=1 and no new access was accepted.
- R12: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_addr` and `out_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Sample the configuration inputs into the mode registers |
| cfg_dimm_style | input | 1 | 1: decode from DIMM sizes; 0: decode from interleave fields |
| cfg_read_ok | input | 1 | 0 marks the configuration read as failed |
| cfg_chan_mode | input | 2 | 0 single, 1 asymmetric, 2 interleaved, 3 reserved |
| cfg_xor_off | input | 1 | Channel XOR disabled |
| cfg_xor_b17 | input | 1 | Channel XOR uses bit 17 (else bit 11) |
| cfg_dimm_a | input | DIMM_W | Size field of channel 0 |
| cfg_dimm_b | input | DIMM_W | Size field of channel 1 |
| in_valid | input | 1 | Access request valid |
| in_ready | output | 1 | Access can be accepted |
| in_tile | input | 2 | Tiling kind of the access |
| in_addr | input | ADDR_W | Byte address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_addr | output | ADDR_W | Rewritten address |
| out_err | output | 1 | Tiled access made while the mode was unknown |
| mode_x | output | 3 | Current mode for X-tiled accesses |
| mode_y | output | 3 | Current mode for Y-tiled accesses |

## Verification
The assertions assume that `in_tile`, `in_addr` and the configuration inputs are known values whenever a handshake or load samples them. They also assume that `out_ready` does not depend combinationally on `in_ready`.

The stimulus changes inputs only just after the falling edge, so every sampling edge sees stable values. It covers each configuration branch of both decode styles, including the unknown mode. For each configuration it sends X, Y and linear accesses at addresses with the relevant bits set. A stall phase holds `out_ready` low so that backpressure reaches `in_ready`.

// File: rtl/swz_pkg.sv
`timescale 1ns/1ps
package swz_pkg;

    typedef enum logic [2:0] {
        SWZ_NONE      = 3'd0,
        SWZ_B9        = 3'd1,
        SWZ_B9_10     = 3'd2,
        SWZ_B9_11     = 3'd3,
        SWZ_B9_10_11  = 3'd4,
        SWZ_B9_17     = 3'd5,
        SWZ_B9_10_17  = 3'd6,
        SWZ_UNKNOWN   = 3'd7
    } swz_mode_e;

    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_RSVD   = 2'd3
    } tile_kind_e;

    typedef enum logic [1:0] {
        CHAN_SINGLE = 2'd0,
        CHAN_ASYM   = 2'd1,
        CHAN_INTLV  = 2'd2,
        CHAN_RSVD   = 2'd3
    } chan_mode_e;

    localparam int SWZ_NUM_TERMS = 4;

    // Mask of XOR terms in the order {bit17, bit11, bit10, bit9}
    function automatic logic [SWZ_NUM_TERMS-1:0] swz_term_mask(input swz_mode_e m);
        case (m)
            SWZ_B9:       return 4'b0001;
            SWZ_B9_10:    return 4'b0011;
            SWZ_B9_11:    return 4'b0101;
            SWZ_B9_10_11: return 4'b0111;
            SWZ_B9_17:    return 4'b1001;
            SWZ_B9_10_17: return 4'b1011;
            default:      return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/swz_mode_decode.sv
`timescale 1ns/1ps
module swz_mode_decode
    import swz_pkg::*;
#(
    parameter int DIMM_W = 8
) (
    input  logic              dimm_style_i,
    input  logic              read_ok_i,
    input  logic [1:0]        chan_mode_i,
    input  logic              xor_off_i,
    input  logic              xor_b17_i,
    input  logic [DIMM_W-1:0] dimm_a_i,
    input  logic [DIMM_W-1:0] dimm_b_i,
    output swz_mode_e         mode_x_o,
    output swz_mode_e         mode_y_o
);

    always_comb begin
        mode_x_o = SWZ_NONE;
        mode_y_o = SWZ_NONE;
        if (!read_ok_i) begin
            mode_x_o = SWZ_UNKNOWN;
            mode_y_o = SWZ_UNKNOWN;
        end else if (dimm_style_i) begin
            if (dimm_a_i == dimm_b_i) begin
                mode_x_o = SWZ_B9_10;
                mode_y_o = SWZ_B9;
            end
        end else begin
            case (chan_mode_e'(chan_mode_i))
                CHAN_INTLV: begin
                    if (xor_off_i) begin
                        mode_x_o = SWZ_B9_10;
                        mode_y_o = SWZ_B9;
                    end else if (xor_b17_i) begin
                        mode_x_o = SWZ_B9_10_17;
                        mode_y_o = SWZ_B9_17;
                    end else begin
                        mode_x_o = SWZ_B9_10_11;
                        mode_y_o = SWZ_B9_11;
                    end
                end
                CHAN_RSVD: begin
                    mode_x_o = SWZ_UNKNOWN;
                    mode_y_o = SWZ_UNKNOWN;
                end
                default: begin
                    mode_x_o = SWZ_NONE;
                    mode_y_o = SWZ_NONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/swz_bit6_xor.sv
`timescale 1ns/1ps
module swz_bit6_xor
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  swz_mode_e         mode_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int TARGET_BIT = 6;
    localparam int TERM_POS [SWZ_NUM_TERMS] = '{9, 10, 11, 17};

    logic [SWZ_NUM_TERMS-1:0] mask;
    logic [SWZ_NUM_TERMS-1:0] term;

    assign mask = swz_term_mask(mode_i);

    for (genvar g = 0; g < SWZ_NUM_TERMS; g++) begin : g_term
        assign term[g] = mask[g] & addr_i[TERM_POS[g]];
    end

    always_comb begin
        addr_o             = addr_i;
        addr_o[TARGET_BIT] = addr_i[TARGET_BIT] ^ (^term);
    end

endmodule

// File: rtl/swz_top.sv
`timescale 1ns/1ps
module swz_top
    import swz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIMM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_dimm_style,
    input  logic              cfg_read_ok,
    input  logic [1:0]        cfg_chan_mode,
    input  logic              cfg_xor_off,
    input  logic              cfg_xor_b17,
    input  logic [DIMM_W-1:0] cfg_dimm_a,
    input  logic [DIMM_W-1:0] cfg_dimm_b,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_tile,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_err,
    output logic [2:0]        mode_x,
    output logic [2:0]        mode_y
);

    localparam logic [ADDR_W-1:0] BIT6_ONLY = ADDR_W'(64);

    typedef struct packed {
        swz_mode_e         mode_x;
        swz_mode_e         mode_y;
        logic              ov;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } state_t;

    state_t    st_d, st_q;
    swz_mode_e dec_x, dec_y;
    swz_mode_e sel_mode;
    logic      tiled;
    logic      fire;
    logic [ADDR_W-1:0] xl_addr;

    swz_mode_decode #(.DIMM_W(DIMM_W)) i_decode (
        .dimm_style_i (cfg_dimm_style),
        .read_ok_i    (cfg_read_ok),
        .chan_mode_i  (cfg_chan_mode),
        .xor_off_i    (cfg_xor_off),
        .xor_b17_i    (cfg_xor_b17),
        .dimm_a_i     (cfg_dimm_a),
        .dimm_b_i     (cfg_dimm_b),
        .mode_x_o     (dec_x),
        .mode_y_o     (dec_y)
    );

    always_comb begin
        tiled    = 1'b0;
        sel_mode = SWZ_NONE;
        case (tile_kind_e'(in_tile))
            TILE_X: begin
                tiled    = 1'b1;
                sel_mode = st_q.mode_x;
            end
            TILE_Y: begin
                tiled    = 1'b1;
                sel_mode = st_q.mode_y;
            end
            default: begin
                tiled    = 1'b0;
                sel_mode = SWZ_NONE;
            end
        endcase
    end

    swz_bit6_xor #(.ADDR_W(ADDR_W)) i_xor (
        .addr_i (in_addr),
        .mode_i (sel_mode),
        .addr_o (xl_addr)
    );

    assign in_ready = !st_q.ov || out_ready;
    assign fire     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.mode_x = dec_x;
            st_d.mode_y = dec_y;
        end
        if (fire) begin
            st_d.ov   = 1'b1;
            st_d.addr = xl_addr;
            st_d.err  = tiled && (sel_mode == SWZ_UNKNOWN);
        end else if (out_ready) begin
            st_d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode_x <= SWZ_UNKNOWN;
            st_q.mode_y <= SWZ_UNKNOWN;
            st_q.ov     <= 1'b0;
            st_q.addr   <= '0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_addr  = st_q.addr;
    assign out_err   = st_q.err;
    assign mode_x    = st_q.mode_x;
    assign mode_y    = st_q.mode_y;

    // Failed configuration read must leave both modes unknown
    assert_badread_unknown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !cfg_read_ok) |=> (mode_x == 3'd7 && mode_y == 3'd7));

    // Modes only move on a load
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(mode_x) && $stable(mode_y)));

    // Only bit 6 may differ between an accepted address and its result
    assert_only_bit6_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (((out_addr ^ $past(in_addr)) & ~BIT6_ONLY) == '0));

    // Linear accesses pass unchanged without error
    assert_linear_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !tiled) |=> (out_addr == $past(in_addr) && !out_err));

    // Tiled access in unknown mode flags error and passes unchanged
    assert_unknown_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ((in_tile == 2'd1 && mode_x == 3'd7) || (in_tile == 2'd2 && mode_y == 3'd7)))
        |=> (out_err && out_addr == $past(in_addr)));

    // Accepted access is valid one cycle later
    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);

    // Stalled output holds
    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err)));

endmodule

// File: tb/test_swz_top.sv
`timescale 1ns/1ps
module test_swz_top;

    localparam int AW = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic          cfg_dimm_style = 1'b0;
    logic          cfg_read_ok = 1'b1;
    logic [1:0]    cfg_chan_mode = 2'd0;
    logic          cfg_xor_off = 1'b0;
    logic          cfg_xor_b17 = 1'b0;
    logic [DW-1:0] cfg_dimm_a = '0;
    logic [DW-1:0] cfg_dimm_b = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_tile = 2'd0;
    logic [AW-1:0] in_addr = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic          out_err;
    logic [2:0]    mode_x, mode_y;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    // reference model state
    int            m_mx = 7, m_my = 7;
    bit            m_ov = 0;
    logic [AW-1:0] m_addr = '0;
    bit            m_err = 0;

    always #4 clk = ~clk;

    swz_top #(.ADDR_W(AW), .DIMM_W(DW)) i_swz_top (
        .clk, .rst_n, .cfg_load, .cfg_dimm_style, .cfg_read_ok, .cfg_chan_mode,
        .cfg_xor_off, .cfg_xor_b17, .cfg_dimm_a, .cfg_dimm_b,
        .in_valid, .in_ready, .in_tile, .in_addr,
        .out_valid, .out_ready, .out_addr, .out_err, .mode_x, .mode_y
    );

    function automatic void check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    // expected modes from the requirement table; returns {x,y}
    function automatic void exp_modes(output int x, output int y);
        if (!cfg_read_ok) begin x = 7; y = 7; end
        else if (cfg_dimm_style) begin
            if (cfg_dimm_a == cfg_dimm_b) begin x = 2; y = 1; end
            else begin x = 0; y = 0; end
        end else if (cfg_chan_mode == 2'd3) begin x = 7; y = 7; end
        else if (cfg_chan_mode != 2'd2) begin x = 0; y = 0; end
        else if (cfg_xor_off) begin x = 2; y = 1; end
        else if (cfg_xor_b17) begin x = 6; y = 5; end
        else begin x = 4; y = 3; end
    endfunction

    function automatic logic [AW-1:0] exp_xlate(logic [AW-1:0] a, int m);
        logic [AW-1:0] r = a;
        case (m)
            1: r[6] = a[6] ^ a[9];
            2: r[6] = a[6] ^ a[9] ^ a[10];
            3: r[6] = a[6] ^ a[9] ^ a[11];
            4: r[6] = a[6] ^ a[9] ^ a[10] ^ a[11];
            5: r[6] = a[6] ^ a[9] ^ a[17];
            6: r[6] = a[6] ^ a[9] ^ a[10] ^ a[17];
            default: r = a;
        endcase
        return r;
    endfunction

    // model advances on each rising edge from the inputs it sees
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mx <= 7; m_my <= 7; m_ov <= 0; m_addr <= '0; m_err <= 0;
        end else begin
            int nx, ny, sm;
            bit rdy;
            rdy = !m_ov || out_ready;
            if (cfg_load) begin
                exp_modes(nx, ny);
                m_mx <= nx; m_my <= ny;
            end
            if (in_valid && rdy) begin
                sm = (in_tile == 2'd1) ? m_mx : (in_tile == 2'd2) ? m_my : 0;
                m_ov   <= 1;
                m_err  <= (in_tile == 2'd1 || in_tile == 2'd2) && sm == 7;
                m_addr <= (sm == 7) ? in_addr : exp_xlate(in_addr, sm);
            end else if (out_ready) begin
                m_ov <= 0;
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "mode_x", mode_x, m_mx);
            check(cur_req, "mode_y", mode_y, m_my);
            check("R11", "out_valid", out_valid, m_ov);
            check("R11", "in_ready", in_ready, !m_ov || out_ready);
            if (m_ov) begin
                check(cur_req, "out_addr", out_addr, m_addr);
                check(cur_req, "out_err", out_err, m_err);
            end
        end
    end

    task automatic load_cfg(bit sty, bit ok, logic [1:0] cm, bit xo, bit b17,
                            logic [DW-1:0] da, logic [DW-1:0] db);
        @(negedge clk); #1;
        cfg_dimm_style = sty; cfg_read_ok = ok; cfg_chan_mode = cm;
        cfg_xor_off = xo; cfg_xor_b17 = b17; cfg_dimm_a = da; cfg_dimm_b = db;
        cfg_load = 1;
        @(negedge clk); #1;
        cfg_load = 0;
    endtask

    task automatic send(logic [1:0] t, logic [AW-1:0] a);
        bit r;
        @(negedge clk); #1;
        in_valid = 1; in_tile = t; in_addr = a;
        do begin
            #1 r = in_ready;
            @(posedge clk);
            if (!r) begin @(negedge clk); #1; end
        end while (!r);
        @(negedge clk); #1;
        in_valid = 0;
    endtask

    task automatic send_set(string tiled_req);
        cur_req = tiled_req;
        send(2'd1, 32'h0002_0E40);
        send(2'd1, 32'h0000_0200);
        send(2'd1, 32'h0002_0000);
        send(2'd2, 32'h0000_0A00);
        send(2'd2, 32'h0002_0840);
        send(2'd2, 32'h0000_0C00);
        cur_req = "R9";
        send(2'd0, 32'h0002_0E40);
        send(2'd3, 32'hFFFF_FFFF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #2;
        check("R1", "reset mode_x", mode_x, 7);
        check("R1", "reset mode_y", mode_y, 7);
        check("R1", "reset out_valid", out_valid, 0);
        check("R1", "reset in_ready", in_ready, 1);

        // unknown mode from reset: tiled accesses flagged
        send_set("R10");

        cur_req = "R2";
        load_cfg(0, 1, 2'd0, 0, 0, 8'd4, 8'd2);
        #2 check("R2", "single mode_x", mode_x, 0);
        send_set("R8");
        cur_req = "R2";
        load_cfg(0, 1, 2'd1, 1, 1, 8'd4, 8'd4);
        #2 check("R2", "asym mode_y", mode_y, 0);

        cur_req = "R3";
        load_cfg(0, 1, 2'd2, 1, 1, 8'd1, 8'd2);
        #2 check("R3", "xor-off mode_x", mode_x, 2);
        check("R3", "xor-off mode_y", mode_y, 1);
        send_set("R8");

        cur_req = "R4";
        load_cfg(0, 1, 2'd2, 0, 0, 8'd1, 8'd2);
        #2 check("R4", "bit11 mode_x", mode_x, 4);
        check("R4", "bit11 mode_y", mode_y, 3);
        send_set("R8");
        cur_req = "R4";
        load_cfg(0, 1, 2'd2, 0, 1, 8'd1, 8'd2);
        #2 check("R4", "bit17 mode_x", mode_x, 6);
        check("R4", "bit17 mode_y", mode_y, 5);
        send_set("R8");

        // R7: config inputs move without a load, modes hold
        cur_req = "R7";
        @(negedge clk); #1;
        cfg_read_ok = 0; cfg_chan_mode = 2'd0; cfg_dimm_style = 1;
        repeat (3) @(negedge clk);
        #2 check("R7", "no-load mode_x", mode_x, 6);
        check("R7", "no-load mode_y", mode_y, 5);

        cur_req = "R5";
        load_cfg(0, 0, 2'd2, 0, 1, 8'd3, 8'd3);
        #2 check("R5", "badread mode_x", mode_x, 7);
        send_set("R10");
        cur_req = "R5";
        load_cfg(1, 0, 2'd2, 0, 0, 8'd3, 8'd3);
        #2 check("R5", "badread dimm mode_y", mode_y, 7);
        load_cfg(0, 1, 2'd3, 1, 0, 8'd3, 8'd3);
        #2 check("R5", "reserved chan mode_x", mode_x, 7);

        cur_req = "R6";
        load_cfg(1, 1, 2'd0, 0, 0, 8'd5, 8'd5);
        #2 check("R6", "equal mode_x", mode_x, 2);
        check("R6", "equal mode_y", mode_y, 1);
        send_set("R8");
        cur_req = "R6";
        load_cfg(1, 1, 2'd2, 0, 1, 8'd5, 8'd6);
        #2 check("R6", "unequal mode_x", mode_x, 0);

        // R12 stall: hold out_ready low with accesses queued
        load_cfg(0, 1, 2'd2, 0, 1, 8'd0, 8'd0);
        cur_req = "R12";
        @(negedge clk); #1;
        out_ready = 0;
        in_valid = 1; in_tile = 2'd1; in_addr = 32'h0002_0600;
        @(negedge clk); #1;
        in_addr = 32'h0000_0440;
        repeat (4) @(negedge clk);
        #2 check("R12", "stall out_valid", out_valid, 1);
        check("R12", "stall out_addr", out_addr, exp_xlate(32'h0002_0600, 6));
        check("R11", "stall in_ready", in_ready, 0);
        #1 out_ready = 1;
        @(negedge clk); #1;
        in_valid = 0;
        repeat (3) @(negedge clk);
        #2 check("R11", "drained out_valid", out_valid, 0);

        // back-to-back stream with intermittent backpressure
        cur_req = "R8";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            in_valid  = 1;
            in_tile   = 2'(k % 4);
            in_addr   = $urandom;
            out_ready = (k % 3) != 0;
        end
        @(negedge clk); #1;
        in_valid = 0; out_ready = 1;
        repeat (4) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule